// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block puts a multi-output clock generator into a low-power state and brings it back out. An asynchronous, active-low sleep request is passed through a synchronizer and a stability filter in the core clock domain. Once the filtered request is seen, every output clock group is parked low on its own next falling edge, so no shortened high pulse ever leaves the block. A complementary memory-reference pair, a true output and its inverse, is driven from one source, and when stopped both of its legs are forced low.

Only after every output is parked does the block drop the PLL/VCO enable. One cycle later it drops the crystal-oscillator enable and rests in the sleep state. When the request is withdrawn, both enables return at once and a settle counter runs for a parameterised number of cycles. The outputs are then released, each on a falling edge of its source, so the first pulse after sleep is full width. The settle count is chosen so that the whole wake path stays under the 3 ms power-up limit at the core clock rate. The analog oscillator and PLL are outside the block and appear only as the two enable outputs.

Top module: `clkgen_pwrdn_seq`

## Requirements
- R1: The request pin passes through two synchronizing flops and acts only after the synchronized level has held for two consecutive samples. A low pulse that covers a single rising clock edge is ignored, so `run_ready` stays high. A held request makes `run_ready` fall on the 5th rising edge after the pin goes low.
- R2: Each output parks only on a falling edge of its source and is released only on a falling edge of its source. Every high pulse on every output, the complement leg included, therefore has the full high width of that output's source. This holds before, during and after a sleep cycle.
- R3: While parked, a group output is low, and both legs of the memory-reference pair (`mref_t`, `mref_c`) are low together.
- R4: All outputs are low in the cycle in which `vco_en` falls. `osc_en` falls exactly one cycle after `vco_en`, never before it.
- R5: `sleep_flag` is high only in the sleep state. While it is high, every output is low and both `osc_en` and `vco_en` are low.
- R6: A withdrawn request makes `sleep_flag` fall on the 5th rising edge after the pin goes high. `osc_en` and `vco_en` are both high from that cycle. `run_ready` rises exactly SETTLE_CYCLES+1 cycles after `sleep_flag` falls.
- R7: `run_ready` is high only in the running state. A started shutdown always completes to the sleep state, even if the request is withdrawn first. A started wake always completes to the running state before a new request is acted on.
- R8: During and right after reset, `run_ready`=1, `sleep_flag`=0, `osc_en`=1, `vco_en`=1 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low sleep request |
| grp_src | input | NUM_GRP | Running source clock for each output group |
| mref_src | input | 1 | Source clock of the memory-reference pair |
| grp_out | output | NUM_GRP | Gated group clocks |
| mref_t | output | 1 | Memory-reference true leg |
| mref_c | output | 1 | Memory-reference complement leg |
| osc_en | output | 1 | Crystal-oscillator enable |
| vco_en | output | 1 | PLL/VCO enable |
| sleep_flag | output | 1 | High only in the sleep state |
| run_ready | output | 1 | High only in the running state |

## Verification
Two pairs of events can fall in the same cycle. In the first, the request is withdrawn while the groups are still being parked, so the withdrawal and the last park land together. A two-cycle request pulse provokes this, and the run is judged by the sleep state still being reached, the wake-up latency and full-width pulses afterwards. In the second, a new request arrives in the cycle the settle countdown is running. The bench reasserts the pin right after the sleep flag falls, and the run is judged by seeing the ready output rise for the expected settle time before it drops again. Throughout, a monitor measures every output high pulse against its source's width and checks the enable order at each falling edge.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_STOP     = 3'd1,
    ST_VCO_OFF  = 3'd2,
    ST_XTAL_OFF = 3'd3,
    ST_DOWN     = 3'd4,
    ST_WAKE     = 3'd5
  } pd_state_e;

  // number of cycles spent in ST_WAKE for a given reload value
  function automatic int wake_cycles(input int settle);
    return settle + 1;
  endfunction

  // a falling edge of a sampled clock: high last sample, low now
  function automatic logic is_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

endpackage

// File: rtl/pd_req_filter.sv
module pd_req_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic req_pin_n,
  output logic req_act
);
  logic s1_n, s2_n, s3_n, filt_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_n   <= 1'b1;
      s2_n   <= 1'b1;
      s3_n   <= 1'b1;
      filt_n <= 1'b1;
    end else begin
      s1_n <= req_pin_n;
      s2_n <= s1_n;
      s3_n <= s2_n;
      if (s2_n == s3_n) filt_n <= s2_n;
    end
  end

  assign req_act = ~filt_n;

  // R1: a request is taken only after two equal synchronized samples
  assert_req_two_samples_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_n) |-> (!$past(s2_n, 1) && !$past(s2_n, 2)));

endmodule

// File: rtl/pd_gate_cell.sv
module pd_gate_cell #(
  parameter bit DUAL = 1'b0,
  localparam int QW = DUAL ? 2 : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src,
  input  logic          stop,
  output logic [QW-1:0] q,
  output logic          parked
);
  import pwrdn_pkg::*;

  logic src_prev, park_q, park_d, fall;

  assign fall   = is_fall(src_prev, src);
  assign park_d = stop ? (park_q | fall) : (park_q & ~fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_prev <= 1'b0;
      park_q   <= 1'b0;
    end else begin
      src_prev <= src;
      park_q   <= park_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q[0] <= 1'b0;
    else        q[0] <= src & ~park_d;
  end

  generate
    if (DUAL) begin : g_comp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[QW-1] <= 1'b0;
        else        q[QW-1] <= ~src & ~park_d;
      end
    end
  endgenerate

  assign parked = park_q;

  // R3: a parked cell drives every leg low
  assert_parked_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    park_q |-> (q == '0));

  // R2: parking happens on a falling edge of the true leg
  assert_park_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(park_q) |-> $fell(q[0]));

endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm #(
  parameter int SETTLE_CYCLES = 1000,
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_act,
  input  logic all_parked,
  output logic stop,
  output logic osc_en,
  output logic vco_en,
  output logic sleep_flag,
  output logic run_ready
);
  import pwrdn_pkg::*;

  pd_state_e        state, state_nx;
  logic [CNT_W-1:0] settle_cnt;
  logic             settle_done;

  assign settle_done = (settle_cnt == '0);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:      if (req_act)     state_nx = ST_STOP;
      ST_STOP:     if (all_parked)  state_nx = ST_VCO_OFF;
      ST_VCO_OFF:                   state_nx = ST_XTAL_OFF;
      ST_XTAL_OFF:                  state_nx = ST_DOWN;
      ST_DOWN:     if (!req_act)    state_nx = ST_WAKE;
      ST_WAKE:     if (settle_done) state_nx = ST_RUN;
      default:                      state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      settle_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_DOWN)                     settle_cnt <= CNT_W'(SETTLE_CYCLES);
      else if (state == ST_WAKE && !settle_done) settle_cnt <= settle_cnt - 1'b1;
    end
  end

  assign stop       = (state != ST_RUN);
  assign vco_en     = !(state inside {ST_VCO_OFF, ST_XTAL_OFF, ST_DOWN});
  assign osc_en     = !(state inside {ST_XTAL_OFF, ST_DOWN});
  assign sleep_flag = (state == ST_DOWN);
  assign run_ready  = (state == ST_RUN);

  // R4: oscillator goes off one cycle after the VCO
  assert_osc_after_vco_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> (!$past(vco_en, 1) && $past(vco_en, 2)));

  // R5: both enables low in the sleep state
  assert_down_enables_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_flag |-> (!osc_en && !vco_en));

  // R6: ready returns only out of the wake countdown
  assert_ready_from_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_ready) |-> ($past(state) == ST_WAKE));

  // R7: a started shutdown is not abandoned
  assert_stop_commits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_STOP) |-> (state inside {ST_STOP, ST_VCO_OFF}));

endmodule

// File: rtl/clkgen_pwrdn_seq.sv
module clkgen_pwrdn_seq #(
  parameter int NUM_GRP       = 3,
  parameter int SETTLE_CYCLES = 1000,
  localparam int NCELL        = NUM_GRP + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pd_req_n,
  input  logic [NUM_GRP-1:0] grp_src,
  input  logic               mref_src,
  output logic [NUM_GRP-1:0] grp_out,
  output logic               mref_t,
  output logic               mref_c,
  output logic               osc_en,
  output logic               vco_en,
  output logic               sleep_flag,
  output logic               run_ready
);
  logic             req_act;
  logic             stop;
  logic [NCELL-1:0] parked;
  logic [1:0]       mref_q;
  logic             all_parked;

  pd_req_filter u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_pin_n (pd_req_n),
    .req_act   (req_act)
  );

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      pd_gate_cell #(.DUAL(1'b0)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (grp_src[g]),
        .stop   (stop),
        .q      (grp_out[g +: 1]),
        .parked (parked[g])
      );
    end
  endgenerate

  pd_gate_cell #(.DUAL(1'b1)) u_mref (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (mref_src),
    .stop   (stop),
    .q      (mref_q),
    .parked (parked[NUM_GRP])
  );

  assign mref_t     = mref_q[0];
  assign mref_c     = mref_q[1];
  assign all_parked = &parked;

  pd_seq_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_act    (req_act),
    .all_parked (all_parked),
    .stop       (stop),
    .osc_en     (osc_en),
    .vco_en     (vco_en),
    .sleep_flag (sleep_flag),
    .run_ready  (run_ready)
  );

  // R4: every output is already low when the VCO is turned off
  assert_quiet_before_vco_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vco_en) |-> (grp_out == '0 && !mref_t && !mref_c));

  // R5: nothing toggles while asleep
  assert_down_outputs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_flag |-> (grp_out == '0 && !mref_t && !mref_c));

  // R3: complement leg never high while the pair is parked
  assert_pair_both_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    parked[NUM_GRP] |-> (!mref_t && !mref_c));

endmodule

// File: tb/sim_clkgen_pwrdn_seq.sv
module sim_clkgen_pwrdn_seq;
  localparam int NG   = 3;
  localparam int ST   = 20;
  localparam int NOBS = NG + 2;
  // hold cycles, expect sleep, exact exit latency known
  localparam int NVEC = 5;
  localparam int VEC [NVEC][3] = '{'{1, 0, 0}, '{2, 1, 0}, '{6, 1, 0},
                                   '{40, 1, 1}, '{100, 1, 1}};

  logic clk = 1'b0, rst_n = 1'b0, pd_req_n = 1'b1;
  logic [NG-1:0] grp_src = '0;
  logic mref_src = 1'b0;
  logic [NG-1:0] grp_out;
  logic mref_t, mref_c, osc_en, vco_en, sleep_flag, run_ready;

  always #2 clk = ~clk;

  clkgen_pwrdn_seq #(.NUM_GRP(NG), .SETTLE_CYCLES(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .grp_src(grp_src),
    .mref_src(mref_src), .grp_out(grp_out), .mref_t(mref_t), .mref_c(mref_c),
    .osc_en(osc_en), .vco_en(vco_en), .sleep_flag(sleep_flag), .run_ready(run_ready)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit run_src = 1'b0, mon_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_width(input int i);
    return (i < NG) ? i + 1 : 2;
  endfunction

  // source clocks: group g has half period g+1, the pair half period 2
  int scnt [NG+1];
  always @(negedge clk) if (run_src) begin
    for (int g = 0; g < NG; g++) begin
      if (scnt[g] == g) begin scnt[g] = 0; grp_src[g] <= ~grp_src[g]; end
      else scnt[g]++;
    end
    if (scnt[NG] == 1) begin scnt[NG] = 0; mref_src <= ~mref_src; end
    else scnt[NG]++;
  end

  // monitors
  logic [NOBS-1:0] obs, obs_prev = '0;
  int  run_len [NOBS];
  bit  armed [NOBS];
  int  rises = 0;
  logic prev_vco = 1'b1, prev_osc = 1'b1, prev_sleep = 1'b0, prev_ready = 1'b1;
  int  vco_fall_cyc = -10, sleep_fall_cyc = -1;

  always @(negedge clk) begin
    cyc++;
    obs = {mref_c, mref_t, grp_out};
    if (mon_en) begin
      for (int i = 0; i < NOBS; i++) begin
        if (obs[i] && !obs_prev[i]) begin run_len[i] = 1; armed[i] = 1'b1; rises++; end
        else if (obs[i]) run_len[i]++;
        else if (obs_prev[i] && armed[i])
          chk(run_len[i] == exp_width(i), "R2 full-width high pulse", run_len[i], exp_width(i));
      end
      if (prev_vco && !vco_en) begin
        chk(obs == '0, "R4 outputs low at vco off", int'(obs), 0);
        vco_fall_cyc = cyc;
      end
      if (prev_osc && !osc_en)
        chk(cyc - vco_fall_cyc == 1, "R4 osc off one cycle after vco", cyc - vco_fall_cyc, 1);
      if (sleep_flag && !prev_sleep) begin
        chk(obs == '0, "R5 outputs low asleep", int'(obs), 0);
        chk(!osc_en && !vco_en, "R5 enables low asleep", int'({osc_en, vco_en}), 0);
        chk(!run_ready, "R7 ready low asleep", int'(run_ready), 0);
      end
      if (sleep_flag) chk(obs == '0, "R3 pair and groups low in sleep", int'(obs), 0);
      if (!sleep_flag && prev_sleep) begin
        sleep_fall_cyc = cyc;
        chk(osc_en && vco_en, "R6 enables back at wake", int'({osc_en, vco_en}), 3);
      end
      if (run_ready && !prev_ready && sleep_fall_cyc >= 0)
        chk(cyc - sleep_fall_cyc == ST + 1, "R6 settle time", cyc - sleep_fall_cyc, ST + 1);
    end
    obs_prev   = obs;
    prev_vco   = vco_en;
    prev_osc   = osc_en;
    prev_sleep = sleep_flag;
    prev_ready = run_ready;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_vec(input int hold, input int exp_down, input int exact);
    int ready_lat = -1, exit_lat = -1, rel = -1;
    bit saw_down = 1'b0, down_before_rel = 1'b0;
    @(negedge clk);
    pd_req_n = 1'b0;
    for (int c = 1; c <= hold + ST + 100; c++) begin
      @(negedge clk);
      if (!run_ready && ready_lat < 0) ready_lat = c;
      if (sleep_flag) saw_down = 1'b1;
      if (rel >= 0 && down_before_rel && exit_lat < 0 && !sleep_flag) exit_lat = c - rel;
      if (c == hold) begin
        pd_req_n = 1'b1;
        rel = c;
        down_before_rel = saw_down;
      end
    end
    if (exp_down != 0) begin
      chk(ready_lat == 5, "R1 request to ready low", ready_lat, 5);
      chk(saw_down, "R7 shutdown completes", int'(saw_down), 1);
      if (exact != 0) chk(exit_lat == 5, "R6 release to wake", exit_lat, 5);
    end else begin
      chk(ready_lat == -1, "R1 single-edge pulse ignored", ready_lat, -1);
      chk(!saw_down, "R1 no sleep on glitch", int'(saw_down), 0);
    end
    chk(run_ready, "R7 back in run", int'(run_ready), 1);
  endtask

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    chk(run_ready, "R8 reset ready", int'(run_ready), 1);
    chk(!sleep_flag, "R8 reset sleep flag", int'(sleep_flag), 0);
    chk(osc_en && vco_en, "R8 reset enables", int'({osc_en, vco_en}), 3);
    chk({grp_out, mref_t, mref_c} == '0, "R8 reset outputs", int'({grp_out, mref_t, mref_c}), 0);
    rst_n   = 1'b1;
    run_src = 1'b1;
    @(negedge clk);
    chk(run_ready && osc_en && vco_en && !sleep_flag, "R8 after reset",
        int'({run_ready, osc_en, vco_en, sleep_flag}), 14);
    repeat (10) @(negedge clk);
    mon_en = 1'b1;
    repeat (40) @(negedge clk);
    chk(rises >= NOBS, "R2 outputs run when idle", rises, NOBS);

    for (int v = 0; v < NVEC; v++) run_vec(VEC[v][0], VEC[v][1], VEC[v][2]);

    // R7 new request during the wake countdown
    begin
      int guard = 0;
      bit saw_ready = 1'b0, slept_again = 1'b0;
      @(negedge clk); pd_req_n = 1'b0;
      while (!sleep_flag && guard < 200) begin @(negedge clk); guard++; end
      pd_req_n = 1'b1;
      guard = 0;
      while (sleep_flag && guard < 200) begin @(negedge clk); guard++; end
      @(negedge clk); pd_req_n = 1'b0;
      for (int c = 0; c < ST + 60; c++) begin
        @(negedge clk);
        if (run_ready) saw_ready = 1'b1;
        if (saw_ready && sleep_flag) slept_again = 1'b1;
      end
      chk(saw_ready, "R7 wake completes before new request", int'(saw_ready), 1);
      chk(slept_again, "R7 new request then honoured", int'(slept_again), 1);
      pd_req_n = 1'b1;
      repeat (ST + 30) @(negedge clk);
      chk(run_ready, "R7 final run", int'(run_ready), 1);
    end

    repeat (20) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule